// File: doc/BRIEF.md
# Descriptor-Chained Frame Buffer Write Engine

This block is a bus-master write engine. It moves formatted pixel words out of a FIFO and into frame buffers in memory. It does not use a fixed base-address register. Each frame's destination comes from a small descriptor held in memory. A descriptor is three consecutive 32-bit words: the buffer start address, a control word and a link to the next descriptor. Descriptors can be chained into a ring, so successive frames rotate through two or more buffers. One example is a pair of buffers used alternately.

Software supplies the address of the first descriptor and then writes the start value to the control input. The engine then runs a loop, one pass per frame:
- It reads the three descriptor words.
- It drains the FIFO into the buffer using fixed-length bursts. A burst starts only when the FIFO holds enough words for a whole burst.
- After the frame-end marker, it writes any shorter remainder.
- It pulses a completion flag together with the index of the buffer it has just filled.
- If the chain bit is set, it follows the link to the next descriptor. Otherwise it goes idle.

The memory port is word based. It has a request, a grant and a write-enable. Read data is returned in the cycle in which the grant is given.

Top module: `fb_ring_dma`

## Requirements
- R1: Writing exactly 0x00000001 on the control input while idle starts the engine. It then reads three words at the descriptor pointer P, at P+4 and at P+8, in that order: buffer address, control word and link. Any other control value, or any control write while the engine is busy, is ignored.
- R2: When bit 1 (store) of the descriptor control word is set, the words of a frame are written starting at the descriptor's buffer address. The address rises by 4 per word. It returns to the new descriptor's buffer address at every frame.
- R3: A write burst is BURST_LEN consecutive beats. Before the frame-end marker, a burst starts only when `fifo_level` is at least BURST_LEN. No write request is made while the FIFO holds fewer words.
- R4: After a `frame_end` pulse, a remainder of fewer than BURST_LEN words is written as one shorter final burst. The frame is complete once the FIFO is empty.
- R5: At the end of each frame, `frame_done` is high for exactly one cycle. At the same time, `frame_idx` gives the position of the completed buffer in the chain: 0 for the first frame after a start, then counting up and wrapping modulo 2^IDX_W.
- R6: When bit 0 (chain) of the control word is set, the engine fetches the next descriptor from the link address. A ring of descriptors therefore sends frame n to buffer n modulo the ring length.
- R7: When the chain bit is clear, the engine returns to idle after that frame's completion pulse and makes no further memory requests.
- R8: When the store bit is clear, the frame's words are still taken from the FIFO, but no memory write is issued.
- R9: While reset is applied, `idle` is high and `mem_req`, `fifo_pop` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_ctrl_we | input | 1 | Control write strobe |
| reg_ctrl_wdata | input | 32 | Control write value (0x00000001 = start) |
| reg_desc_ptr | input | 32 | Address of the first descriptor |
| fifo_data | input | 32 | Word at the FIFO head |
| fifo_level | input | LVL_W | Number of words in the FIFO |
| fifo_pop | output | 1 | Removes the head word |
| frame_end | input | 1 | Pulse: the last word of the frame has entered the FIFO |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write beat, 0 = descriptor read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_idx | output | IDX_W | Index of the completed buffer |
| idle | output | 1 | Engine is stopped |

## Verification
The hardest case to reach is a descriptor ring that wraps back to its first entry and then terminates.

The bench builds a three-entry ring and enables a grant that stalls on every other cycle. After the first frame completes, it rewrites the control word of the first descriptor through a memory backdoor. The engine revisits that descriptor on the fourth frame and sees the changed control word. The bench can then confirm four things:
- the buffer contents were overwritten on wrap;
- all twelve descriptor reads happened in order;
- the index sequence is correct;
- the engine stops cleanly.

A second case that is hard to reach is a remainder burst shorter than BURST_LEN. The bench reaches it by pushing a word count that is not a multiple of the burst length.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int CHAIN_BIT  = 0;
  localparam int STORE_BIT  = 1;
  localparam logic [WORD_W-1:0] START_CODE = 32'h0000_0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_MOVE,
    ST_DONE
  } eng_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] buf_base;
    logic [1:0]        ctrl;
    logic [ADDR_W-1:0] link;
  } frame_desc_t;
endpackage

// File: rtl/desc_loader.sv
module desc_loader
  import fbdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_ptr,
  input  logic              word_ack,
  input  logic [WORD_W-1:0] word_in,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              last_word,
  output frame_desc_t       desc
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [1:0]        widx_q, widx_d;
  frame_desc_t       desc_q, desc_d;

  always_comb begin
    ptr_d  = ptr_q;
    widx_d = widx_q;
    desc_d = desc_q;
    if (restart) begin
      ptr_d  = restart_ptr;
      widx_d = 2'd0;
    end else if (word_ack) begin
      case (widx_q)
        2'd0:    desc_d.buf_base = word_in;
        2'd1:    desc_d.ctrl     = word_in[1:0];
        default: desc_d.link     = word_in;
      endcase
      widx_d = (widx_q == 2'd2) ? 2'd0 : widx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      widx_q <= '0;
      desc_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      widx_q <= widx_d;
      desc_q <= desc_d;
    end
  end

  assign rd_addr   = ptr_q + ADDR_W'({widx_q, 2'b00});
  assign last_word = (widx_q == 2'd2);
  assign desc      = desc_q;

  // R1
  restart_vs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !word_ack);
endmodule

// File: rtl/beat_engine.sv
module beat_engine
  import fbdma_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_load,
  input  logic [ADDR_W-1:0] frame_base,
  input  logic              burst_load,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              beat,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              last_beat
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (frame_load)      addr_d = frame_base;
    else if (beat)       addr_d = addr_q + ADDR_W'(4);
    if (burst_load)      cnt_d  = burst_len;
    else if (beat)       cnt_d  = cnt_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wr_addr   = addr_q;
  assign last_beat = (cnt_q == LEN_W'(1));

  // R3
  beat_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (cnt_q != '0));
endmodule

// File: rtl/fb_ring_dma.sv
module fb_ring_dma
  import fbdma_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int LVL_W     = 6,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_ctrl_we,
  input  logic [31:0]       reg_ctrl_wdata,
  input  logic [31:0]       reg_desc_ptr,
  input  logic [31:0]       fifo_data,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_pop,
  input  logic              frame_end,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              frame_done,
  output logic [IDX_W-1:0]  frame_idx,
  output logic              idle
);
  localparam int LEN_W = $clog2(BURST_LEN + 1);

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  eng_state_e        state_q, state_d;
  logic              end_pend_q, end_pend_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              go, full, store;
  logic              ld_restart, ld_ack, ld_last;
  logic [ADDR_W-1:0] ld_ptr, rd_addr, wr_addr;
  frame_desc_t       desc;
  logic              fr_load, bu_load, beat, last_beat;
  logic [LEN_W-1:0]  bu_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign go    = reg_ctrl_we && (reg_ctrl_wdata == START_CODE);
  assign full  = fifo_level >= LVL_W'(BURST_LEN);
  assign store = desc.ctrl[STORE_BIT];

  always_comb begin
    state_d    = state_q;
    ld_restart = 1'b0;
    ld_ptr     = reg_desc_ptr;
    ld_ack     = 1'b0;
    fr_load    = 1'b0;
    bu_load    = 1'b0;
    bu_len     = LEN_W'(BURST_LEN);
    beat       = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        ld_restart = 1'b1;
        state_d    = ST_FETCH;
      end
      ST_FETCH: begin
        ld_ack = mem_gnt;
        if (mem_gnt && ld_last) begin
          fr_load = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (full) begin
          bu_load = 1'b1;
          state_d = ST_MOVE;
        end else if (end_pend_q && fifo_level != '0) begin
          bu_load = 1'b1;
          bu_len  = LEN_W'(fifo_level);
          state_d = ST_MOVE;
        end else if (end_pend_q) begin
          state_d = ST_DONE;
        end
      end
      ST_MOVE: begin
        beat = store ? mem_gnt : 1'b1;
        if (beat && last_beat) state_d = ST_WAIT;
      end
      ST_DONE: begin
        if (desc.ctrl[CHAIN_BIT]) begin
          ld_restart = 1'b1;
          ld_ptr     = desc.link;
          state_d    = ST_FETCH;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    end_pend_d = (end_pend_q && state_q != ST_DONE) ||
                 (frame_end && state_q != ST_IDLE);
    idx_d = idx_q;
    if (state_q == ST_IDLE && go) idx_d = '0;
    else if (state_q == ST_DONE)  idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      end_pend_q <= 1'b0;
      idx_q      <= '0;
    end else begin
      state_q    <= state_d;
      end_pend_q <= end_pend_d;
      idx_q      <= idx_d;
    end
  end

  desc_loader u_loader (
    .clk(clk), .rst_n(rst_n_s), .restart(ld_restart), .restart_ptr(ld_ptr),
    .word_ack(ld_ack), .word_in(mem_rdata), .rd_addr(rd_addr),
    .last_word(ld_last), .desc(desc)
  );

  beat_engine #(.LEN_W(LEN_W)) u_beats (
    .clk(clk), .rst_n(rst_n_s), .frame_load(fr_load), .frame_base(desc.buf_base),
    .burst_load(bu_load), .burst_len(bu_len), .beat(beat),
    .wr_addr(wr_addr), .last_beat(last_beat)
  );

  assign mem_req    = (state_q == ST_FETCH) || (state_q == ST_MOVE && store);
  assign mem_we     = (state_q == ST_MOVE);
  assign mem_addr   = (state_q == ST_FETCH) ? rd_addr : wr_addr;
  assign mem_wdata  = fifo_data;
  assign fifo_pop   = (state_q == ST_MOVE) && beat;
  assign frame_done = (state_q == ST_DONE);
  assign frame_idx  = idx_q;
  assign idle       = (state_q == ST_IDLE);

  // R3
  burst_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(mem_we) && !end_pend_q) |-> ($past(fifo_level) >= LVL_W'(BURST_LEN)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && mem_we && mem_gnt && !last_beat) |=> (mem_addr == $past(mem_addr) + 32'd4));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_done |=> !frame_done);

  // R7
  stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frame_done && !desc.ctrl[CHAIN_BIT]) |=> (idle && !mem_req));

  // R8
  no_write_discard_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_we && !store) |-> !mem_req);
endmodule

// File: tb/fb_ring_dma_tb_top.sv
module fb_ring_dma_tb_top;
  localparam int BL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_ctrl_we = 1'b0;
  logic [31:0] reg_ctrl_wdata = '0;
  logic [31:0] reg_desc_ptr = '0;
  logic [31:0] fifo_data;
  logic [5:0]  fifo_level;
  logic        fifo_pop, frame_end = 1'b0;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        frame_done, idle;
  logic [3:0]  frame_idx;

  always #2 clk = ~clk;

  fb_ring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_ctrl_we(reg_ctrl_we), .reg_ctrl_wdata(reg_ctrl_wdata),
    .reg_desc_ptr(reg_desc_ptr), .fifo_data(fifo_data), .fifo_level(fifo_level),
    .fifo_pop(fifo_pop), .frame_end(frame_end), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .frame_done(frame_done), .frame_idx(frame_idx), .idle(idle)
  );

  // memory model with backdoor
  logic [31:0] mem [0:1023];
  logic        bd_we = 1'b0;
  logic [31:0] bd_addr = '0, bd_data = '0;
  logic        stall_en = 1'b0, stall_tgl = 1'b0;
  assign mem_gnt   = !stall_en || stall_tgl;
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    stall_tgl <= ~stall_tgl;
    if (bd_we) mem[bd_addr[11:2]] <= bd_data;
    else if (mem_req && mem_we && mem_gnt) mem[mem_addr[11:2]] <= mem_wdata;
  end

  // FIFO model
  logic [31:0] fq [0:63];
  logic [5:0]  wp = '0, rp = '0;
  logic [6:0]  cnt = '0;
  logic        push_v = 1'b0;
  logic [31:0] push_d = '0;
  assign fifo_data  = fq[rp];
  assign fifo_level = cnt[5:0];
  always @(posedge clk) begin
    if (push_v) begin fq[wp] <= push_d; wp <= wp + 6'd1; end
    if (fifo_pop) rp <= rp + 6'd1;
    cnt <= cnt + {6'd0, push_v} - {6'd0, fifo_pop};
  end

  // monitors
  int rd_cnt = 0, wr_cnt = 0, short_starts = 0, done_cnt = 0;
  logic [31:0] rd_log [0:63];
  logic [3:0]  done_log [0:63];
  logic        prev_w = 1'b0;
  always @(posedge clk) begin
    if (mem_req && !mem_we && mem_gnt) begin rd_log[rd_cnt] <= mem_addr; rd_cnt <= rd_cnt + 1; end
    if (mem_req && mem_we && mem_gnt) wr_cnt <= wr_cnt + 1;
    prev_w <= mem_req && mem_we;
    if (mem_req && mem_we && !prev_w && fifo_level < 6'(BL)) short_starts <= short_starts + 1;
    if (frame_done) begin done_log[done_cnt] <= frame_idx; done_cnt <= done_cnt + 1; end
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bd_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] buf_a,
                          input logic [31:0] ctl, input logic [31:0] nxt);
    bd_write(at, buf_a); bd_write(at + 4, ctl); bd_write(at + 8, nxt);
  endtask

  task automatic sw_ctrl(input logic [31:0] ptr, input logic [31:0] val);
    @(negedge clk); reg_desc_ptr = ptr; reg_ctrl_wdata = val; reg_ctrl_we = 1'b1;
    @(negedge clk); reg_ctrl_we = 1'b0;
  endtask

  task automatic push_words(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); push_v = 1'b1; push_d = base + i;
    end
    @(negedge clk); push_v = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 3000 && done_cnt < target; i++) @(negedge clk);
    chk("R5 done count", done_cnt, target);
  endtask

  // R9 reset state
  task automatic t_reset();
    @(negedge clk);
    chk("R9 idle", idle, 1); chk("R9 mem_req", mem_req, 0);
    chk("R9 fifo_pop", fifo_pop, 0); chk("R9 frame_done", frame_done, 0);
  endtask

  // R1 non-start value ignored
  task automatic t_bad_start();
    put_desc(32'h100, 32'h400, 32'h2, 32'h0);
    sw_ctrl(32'h100, 32'h3);
    repeat (6) @(negedge clk);
    chk("R1 wrong code keeps idle", idle, 1);
    chk("R1 wrong code no reads", rd_cnt, 0);
  endtask

  // R1 R2 R3 R5 R7 single frame of two bursts
  task automatic t_single();
    int d0;
    d0 = done_cnt;
    sw_ctrl(32'h100, 32'h1);
    push_words(32'hA000, 3);
    repeat (10) @(negedge clk);
    chk("R3 no burst below threshold", wr_cnt, 0);
    push_words(32'hA003, 5);
    pulse_end();
    wait_done(d0 + 1);
    chk("R5 first index", done_log[d0], 0);
    chk("R1 read0", rd_log[0], 32'h100);
    chk("R1 read1", rd_log[1], 32'h104);
    chk("R1 read2", rd_log[2], 32'h108);
    for (int i = 0; i < 8; i++) chk("R2 buffer word", mem[(32'h400 >> 2) + i], 32'hA000 + i);
    chk("R3 full bursts only", short_starts, 0);
    chk("R3 write count", wr_cnt, 8);
    repeat (8) @(negedge clk);
    chk("R7 idle after stop", idle, 1);
    chk("R7 no further reads", rd_cnt, 3);
  endtask

  // R4 tail burst
  task automatic t_tail();
    int w0, s0, d0;
    w0 = wr_cnt; s0 = short_starts; d0 = done_cnt;
    put_desc(32'h140, 32'h500, 32'h2, 32'h0);
    sw_ctrl(32'h140, 32'h1);
    push_words(32'hB000, 6);
    pulse_end();
    wait_done(d0 + 1);
    chk("R4 words written", wr_cnt - w0, 6);
    chk("R4 one short burst", short_starts - s0, 1);
    for (int i = 0; i < 6; i++) chk("R4 tail data", mem[(32'h500 >> 2) + i], 32'hB000 + i);
    chk("R4 fifo drained", {26'd0, fifo_level}, 0);
  endtask

  // R6 ring of three with wrap and stalls
  task automatic t_ring();
    int d0, r0;
    d0 = done_cnt; r0 = rd_cnt;
    stall_en = 1'b1;
    put_desc(32'h100, 32'h400, 32'h3, 32'h110);
    put_desc(32'h110, 32'h600, 32'h3, 32'h120);
    put_desc(32'h120, 32'h800, 32'h3, 32'h100);
    sw_ctrl(32'h100, 32'h1);
    for (int f = 0; f < 4; f++) begin
      push_words(32'h1000 * (f + 1), BL);
      pulse_end();
      wait_done(d0 + f + 1);
      if (f == 0) bd_write(32'h104, 32'h2);
    end
    repeat (8) @(negedge clk);
    stall_en = 1'b0;
    chk("R7 ring stops", idle, 1);
    chk("R6 twelve reads", rd_cnt - r0, 12);
    for (int k = 0; k < 12; k++)
      chk("R6 read order", rd_log[r0 + k], 32'h100 + 32'h10 * (k % 3 == 0 && k == 9 ? 0 : (k / 3) % 3) + 4 * (k % 3));
    for (int f = 0; f < 4; f++) chk("R5 ring index", done_log[d0 + f], f);
    for (int i = 0; i < BL; i++) begin
      chk("R6 buffer0 wrapped", mem[(32'h400 >> 2) + i], 32'h4000 + i);
      chk("R6 buffer1", mem[(32'h600 >> 2) + i], 32'h2000 + i);
      chk("R6 buffer2", mem[(32'h800 >> 2) + i], 32'h3000 + i);
    end
  endtask

  // R8 discard and R1 busy start ignored
  task automatic t_discard();
    int d0, r0, w0;
    put_desc(32'h180, 32'hA00, 32'h0, 32'h0);
    bd_write(32'hA00, 32'hDEADBEEF);
    d0 = done_cnt; r0 = rd_cnt; w0 = wr_cnt;
    sw_ctrl(32'h180, 32'h1);
    repeat (8) @(negedge clk);
    sw_ctrl(32'h300, 32'h1);
    push_words(32'hC000, BL);
    pulse_end();
    wait_done(d0 + 1);
    repeat (8) @(negedge clk);
    chk("R8 no writes", wr_cnt - w0, 0);
    chk("R8 buffer untouched", mem[32'hA00 >> 2], 32'hDEADBEEF);
    chk("R8 words consumed", {26'd0, fifo_level}, 0);
    chk("R1 busy start ignored", rd_cnt - r0, 3);
    chk("R7 idle after discard", idle, 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_bad_start();
    t_single();
    t_tail();
    t_ring();
    t_discard();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule